// File: doc/BRIEF.md
# Display control register decoder

This block sits behind the display control port of a graphics engine. Each write is a 32-bit word. The top byte names a command and the low 24 bits carry its arguments. The block turns these writes into a status word, a horizontal and vertical resolution, and the effective visible width and height of the display window. It also drives the display start position, pulses that reset the engine and its command queue, and a readback register that answers information queries about the drawing environment.

The visible width is a fraction of a 2560-unit horizontal span, scaled to the current horizontal resolution. That fraction is found by a serial divider. While the divider runs, the block deasserts its ready output and holds off the next write. The visible height comes from the vertical window and is doubled in double-height mode. It is ready one cycle after the write that changes it.

A write whose word matches the last stored word for the same command is dropped, except for the two reset commands and the start-position command. This keeps repeated identical programming from restarting the width calculation.

Top module: `disp_ctrl_decoder`

## Requirements
- R1: After rst_ni, and one cycle after an accepted command 0x00, status_o is 0x14802000, hres_o and width_o are 256, vres_o and height_o are 240, and readback_o is 0. Command 0x00 also restores the stored-word table so that entry 3 holds 1 and every other entry holds 0.
- R2: An accepted command 0x00 pulses full_reset_o for one cycle, starting at the clock edge that accepts it. An accepted command 0x00 or 0x01 pulses cmd_reset_o for one cycle with the same timing.
- R3: Command 0x03 copies data bit 0 into status bit 23, the blanking flag. Command 0x04 copies data bits 1:0 into status bits 30:29, the transfer direction field.
- R4: Command 0x05 sets disp_x_o from data bits 9:0 and disp_y_o from data bits 18:10.
- R5: Command 0x06 takes x1 from data bits 11:0 and x2 from data bits 23:12. With sw = x2 - x1 as a signed value, width_o becomes hres_o when sw <= 0 or sw >= 2560. Otherwise width_o becomes floor(sw * hres_o / 2560).
- R6: Command 0x07 takes y1 from data bits 9:0 and y2 from data bits 19:10. The height is y2 - y1, doubled when status bit 19 is set. When that result is <= 0, height_o takes vres_o instead.
- R7: Command 0x08 replaces status bits 22:16: data bits 5:0 go to status bits 22:17 and data bit 6 goes to status bit 16. Width and height are then recomputed. hres_o is {256,368,320,384,512,512,640,640} indexed by status bits 18:16. vres_o is {240,480,256,480} indexed by status bits 20:19.
- R8: Commands 0x10 to 0x1F load readback_o according to data bits 3:0. Keys 2 to 5 load environment register (key) as 20 bits, zero extended. Key 6 loads environment register 5. Key 7 loads the value 2. Any other key loads 0. env_info_i holds register k in bits (k-2)*20 +: 20.
- R9: While the width calculation is pending or running, busy_o or the pending request keeps wr_ready_o low and width_o holds its value. A write held off in this way takes effect only after ready returns.
- R10: For commands 0x02 to 0x0F other than 0x05, a write whose full word equals the stored word for that command is ignored. It starts no width calculation and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Control write strobe |
| wr_data_i | input | 32 | Control word: command in bits 31:24 |
| wr_ready_o | output | 1 | Write accepted at an edge where valid and ready are both high |
| env_info_i | input | 80 | Low 20 bits of environment registers 2 to 5 |
| status_o | output | 32 | Status word |
| hres_o | output | 10 | Horizontal resolution |
| vres_o | output | 9 | Vertical resolution |
| width_o | output | 10 | Effective visible width |
| height_o | output | 11 | Effective visible height |
| disp_x_o | output | 10 | Display start X |
| disp_y_o | output | 9 | Display start Y |
| busy_o | output | 1 | Width divider running |
| full_reset_o | output | 1 | One-cycle full engine reset pulse |
| cmd_reset_o | output | 1 | One-cycle command queue reset pulse |
| readback_o | output | 32 | Information query result |

## Verification
Two kinds of work can compete for the same cycles: a new control write, and a width division still in progress from the previous one. The bench provokes this by keeping valid high with a query word in the cycle right after a window write that needs division. It judges the result in three ways. Ready must be low, and the readback must still hold its old value while busy. After ready returns, both the new width and the query result must match the reference model. A mode write recomputes width and height together, so both results are compared against the model after every such write.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SHADOW_N  = 16;
  localparam int unsigned HRES_W    = 10;
  localparam int unsigned VRES_W    = 9;
  localparam int unsigned WIN_X_W   = 12;
  localparam int unsigned WIN_Y_W   = 10;
  localparam int unsigned HEIGHT_W  = 11;
  localparam int unsigned START_X_W = 10;
  localparam int unsigned START_Y_W = 9;
  localparam int unsigned BLANK_BIT = 23;
  localparam int unsigned DIR_LSB   = 29;
  localparam int unsigned MODE_LSB  = 16;
  localparam int unsigned DBL_BIT   = 19;
  localparam logic [WORD_W-1:0] STATUS_INIT = 32'h1480_2000;
  localparam logic [HRES_W-1:0] HRES_INIT   = 10'd256;
  localparam logic [VRES_W-1:0] VRES_INIT   = 9'd240;

  typedef enum logic [CMD_W-1:0] {
    CMD_FULL_RST = 8'h00,
    CMD_Q_RST    = 8'h01,
    CMD_BLANK    = 8'h03,
    CMD_DIR      = 8'h04,
    CMD_START    = 8'h05,
    CMD_HWIN     = 8'h06,
    CMD_VWIN     = 8'h07,
    CMD_MODE     = 8'h08
  } ctl_cmd_e;

  function automatic logic [HRES_W-1:0] hres_lut(input logic [2:0] idx);
    case (idx)
      3'd0:      return 10'd256;
      3'd1:      return 10'd368;
      3'd2:      return 10'd320;
      3'd3:      return 10'd384;
      3'd4,3'd5: return 10'd512;
      default:   return 10'd640;
    endcase
  endfunction

  function automatic logic [VRES_W-1:0] vres_lut(input logic [1:0] idx);
    case (idx)
      2'd0:    return 9'd240;
      2'd2:    return 9'd256;
      default: return 9'd480;
    endcase
  endfunction
endpackage

// File: rtl/disp_ctrl_div.sv
// Restoring serial divider by a constant, one quotient bit per cycle.
module disp_ctrl_div #(
  parameter int unsigned NUM_W = 22,
  parameter int unsigned DEN   = 2560,
  parameter int unsigned QUO_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam int unsigned REM_W = $clog2(DEN) + 1;
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [REM_W-2:0] rem_q, rem_nx;
  logic [NUM_W-1:0] quo_q, quo_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [REM_W-1:0] trial;
  logic [REM_W-2:0] diff;
  logic             fits;

  always_comb begin
    trial  = {rem_q, quo_q[NUM_W-1]};
    fits   = trial >= REM_W'(DEN);
    diff   = (REM_W-1)'(trial - REM_W'(DEN));
    rem_nx = fits ? diff : trial[REM_W-2:0];
    quo_nx = {quo_q[NUM_W-2:0], fits};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q[QUO_W-1:0];
endmodule

// File: rtl/disp_ctrl_geom.sv
// Visible width and height from window coordinates and resolution.
module disp_ctrl_geom import disp_ctrl_pkg::*; #(
  parameter int unsigned SPAN = 2560
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_full_i,
  input  logic                calc_w_i,
  input  logic                calc_h_i,
  input  logic [HRES_W-1:0]   hres_i,
  input  logic [VRES_W-1:0]   vres_i,
  input  logic                dbl_i,
  input  logic [WIN_X_W-1:0]  x1_i,
  input  logic [WIN_X_W-1:0]  x2_i,
  input  logic [WIN_Y_W-1:0]  y1_i,
  input  logic [WIN_Y_W-1:0]  y2_i,
  output logic [HRES_W-1:0]   width_o,
  output logic [HEIGHT_W-1:0] height_o,
  output logic                busy_o
);
  localparam int unsigned SW_W   = WIN_X_W + 1;
  localparam int unsigned SH_W   = WIN_Y_W + 2;
  localparam int unsigned PROD_W = WIN_X_W + HRES_W;

  logic signed [SW_W-1:0] sw;
  logic signed [SH_W-1:0] sh, sh_eff;
  logic                   full_w;
  logic [PROD_W-1:0]      prod;
  logic [HEIGHT_W-1:0]    h_new;
  logic                   div_done;
  logic [HRES_W-1:0]      div_quo;
  logic [HRES_W-1:0]      width_q;
  logic [HEIGHT_W-1:0]    height_q;

  always_comb begin
    sw     = $signed({1'b0, x2_i}) - $signed({1'b0, x1_i});
    full_w = (sw <= 0) || (sw >= $signed(SW_W'(SPAN)));
    prod   = PROD_W'(sw[WIN_X_W-1:0]) * PROD_W'(hres_i);
    sh     = $signed({2'b00, y2_i}) - $signed({2'b00, y1_i});
    sh_eff = dbl_i ? (sh <<< 1) : sh;
    h_new  = (sh_eff <= 0) ? HEIGHT_W'(vres_i) : sh_eff[HEIGHT_W-1:0];
  end

  disp_ctrl_div #(
    .NUM_W(PROD_W),
    .DEN  (SPAN),
    .QUO_W(HRES_W)
  ) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(calc_w_i && !full_w && !set_full_i),
    .num_i  (prod),
    .busy_o (busy_o),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q  <= HRES_INIT;
      height_q <= HEIGHT_W'(VRES_INIT);
    end else if (set_full_i) begin
      width_q  <= hres_i;
      height_q <= HEIGHT_W'(vres_i);
    end else begin
      if (calc_w_i && full_w) width_q <= hres_i;
      if (div_done)           width_q <= div_quo;
      if (calc_h_i)           height_q <= h_new;
    end
  end

  assign width_o  = width_q;
  assign height_o = height_q;
endmodule

// File: rtl/disp_ctrl_query.sv
// Information query result selection.
module disp_ctrl_query #(
  parameter int unsigned ENV_CNT  = 4,
  parameter int unsigned ENV_W    = 20,
  parameter int unsigned ENV_BASE = 2
) (
  input  logic [3:0]               key_i,
  input  logic [ENV_CNT*ENV_W-1:0] env_i,
  output logic [31:0]              val_o
);
  localparam int unsigned LAST = ENV_CNT - 1;

  logic [ENV_W-1:0] ent [ENV_CNT];

  for (genvar g = 0; g < ENV_CNT; g++) begin : g_ent
    assign ent[g] = env_i[g*ENV_W +: ENV_W];
  end

  always_comb begin
    val_o = '0;
    for (int k = 0; k < ENV_CNT; k++)
      if (key_i == 4'(k + ENV_BASE)) val_o = 32'(ent[k]);
    if (key_i == 4'(ENV_BASE + ENV_CNT)) val_o = 32'(ent[LAST]);
    if (key_i == 4'(ENV_BASE + ENV_CNT + 1)) val_o = 32'd2;
  end
endmodule

// File: rtl/disp_ctrl_decoder.sv
module disp_ctrl_decoder import disp_ctrl_pkg::*; #(
  parameter int unsigned ENV_CNT = 4,
  parameter int unsigned ENV_W   = 20,
  parameter int unsigned SPAN    = 2560
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_valid_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  output logic                     wr_ready_o,
  input  logic [ENV_CNT*ENV_W-1:0] env_info_i,
  output logic [WORD_W-1:0]        status_o,
  output logic [HRES_W-1:0]        hres_o,
  output logic [VRES_W-1:0]        vres_o,
  output logic [HRES_W-1:0]        width_o,
  output logic [HEIGHT_W-1:0]      height_o,
  output logic [START_X_W-1:0]     disp_x_o,
  output logic [START_Y_W-1:0]     disp_y_o,
  output logic                     busy_o,
  output logic                     full_reset_o,
  output logic                     cmd_reset_o,
  output logic [WORD_W-1:0]        readback_o
);
  localparam int unsigned IDX_W = $clog2(SHADOW_N);

  logic [CMD_W-1:0]     cmd;
  logic                 accept, in_shadow, exempt, dup, act;
  logic [WORD_W-1:0]    shadow_q [SHADOW_N];
  logic [WORD_W-1:0]    status_q, status_nx;
  logic [WIN_X_W-1:0]   x1_q, x2_q;
  logic [WIN_Y_W-1:0]   y1_q, y2_q;
  logic [START_X_W-1:0] sx_q;
  logic [START_Y_W-1:0] sy_q;
  logic [WORD_W-1:0]    rb_q, query_val;
  logic                 full_q, qrst_q, calc_w_q, calc_h_q;
  logic                 geom_busy;

  assign cmd       = wr_data_i[WORD_W-1 -: CMD_W];
  assign accept    = wr_valid_i && wr_ready_o;
  assign in_shadow = cmd < CMD_W'(SHADOW_N);
  assign exempt    = (cmd == CMD_FULL_RST) || (cmd == CMD_Q_RST) || (cmd == CMD_START);
  assign dup       = in_shadow && !exempt && (shadow_q[cmd[IDX_W-1:0]] == wr_data_i);
  assign act       = accept && !dup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SHADOW_N; i++) shadow_q[i] <= (i == 3) ? 32'd1 : 32'd0;
    end else if (act && cmd == CMD_FULL_RST) begin
      for (int i = 0; i < SHADOW_N; i++) shadow_q[i] <= (i == 3) ? 32'd1 : 32'd0;
    end else if (act && in_shadow) begin
      shadow_q[cmd[IDX_W-1:0]] <= wr_data_i;
    end
  end

  always_comb begin
    status_nx = status_q;
    case (cmd)
      CMD_FULL_RST: status_nx = STATUS_INIT;
      CMD_BLANK:    status_nx[BLANK_BIT] = wr_data_i[0];
      CMD_DIR:      status_nx[DIR_LSB +: 2] = wr_data_i[1:0];
      CMD_MODE:     status_nx[MODE_LSB +: 7] = {wr_data_i[5:0], wr_data_i[6]};
      default:      ;
    endcase
  end

  disp_ctrl_query #(
    .ENV_CNT (ENV_CNT),
    .ENV_W   (ENV_W),
    .ENV_BASE(2)
  ) query_i (
    .key_i(wr_data_i[3:0]),
    .env_i(env_info_i),
    .val_o(query_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_INIT;
      x1_q     <= '0;
      x2_q     <= '0;
      y1_q     <= '0;
      y2_q     <= '0;
      sx_q     <= '0;
      sy_q     <= '0;
      rb_q     <= '0;
      full_q   <= 1'b0;
      qrst_q   <= 1'b0;
      calc_w_q <= 1'b0;
      calc_h_q <= 1'b0;
    end else begin
      full_q   <= act && (cmd == CMD_FULL_RST);
      qrst_q   <= act && (cmd == CMD_FULL_RST || cmd == CMD_Q_RST);
      calc_w_q <= act && (cmd == CMD_HWIN || cmd == CMD_MODE);
      calc_h_q <= act && (cmd == CMD_VWIN || cmd == CMD_MODE);
      if (act) begin
        status_q <= status_nx;
        if (cmd == CMD_START) begin
          sx_q <= wr_data_i[START_X_W-1:0];
          sy_q <= wr_data_i[START_X_W +: START_Y_W];
        end
        if (cmd == CMD_HWIN) begin
          x1_q <= wr_data_i[WIN_X_W-1:0];
          x2_q <= wr_data_i[WIN_X_W +: WIN_X_W];
        end
        if (cmd == CMD_VWIN) begin
          y1_q <= wr_data_i[WIN_Y_W-1:0];
          y2_q <= wr_data_i[WIN_Y_W +: WIN_Y_W];
        end
        if (cmd == CMD_FULL_RST)       rb_q <= '0;
        else if (cmd[7:4] == 4'h1)     rb_q <= query_val;
      end
    end
  end

  disp_ctrl_geom #(
    .SPAN(SPAN)
  ) geom_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_full_i(full_q),
    .calc_w_i  (calc_w_q),
    .calc_h_i  (calc_h_q),
    .hres_i    (hres_o),
    .vres_i    (vres_o),
    .dbl_i     (status_q[DBL_BIT]),
    .x1_i      (x1_q),
    .x2_i      (x2_q),
    .y1_i      (y1_q),
    .y2_i      (y2_q),
    .width_o   (width_o),
    .height_o  (height_o),
    .busy_o    (geom_busy)
  );

  assign hres_o       = hres_lut(status_q[MODE_LSB +: 3]);
  assign vres_o       = vres_lut(status_q[DBL_BIT +: 2]);
  assign wr_ready_o   = !(geom_busy || calc_w_q);
  assign busy_o       = geom_busy;
  assign status_o     = status_q;
  assign disp_x_o     = sx_q;
  assign disp_y_o     = sy_q;
  assign full_reset_o = full_q;
  assign cmd_reset_o  = qrst_q;
  assign readback_o   = rb_q;
endmodule

// File: rtl/disp_ctrl_decoder_chk.sv
module disp_ctrl_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_valid_i,
  input logic [7:0]  wr_cmd_i,
  input logic        wr_lsb_i,
  input logic        wr_ready_i,
  input logic [31:0] status_i,
  input logic [9:0]  hres_i,
  input logic [9:0]  width_i,
  input logic [10:0] height_i,
  input logic        busy_i,
  input logic        full_reset_i,
  input logic        cmd_reset_i
);
  AST_FULL_RST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_reset_i |-> cmd_reset_i); // R2

  AST_RESET_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_i && wr_cmd_i == 8'h00) |=> (status_i == 32'h1480_2000)); // R1

  AST_BLANK_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_i && wr_cmd_i == 8'h03) |=> (status_i[23] == $past(wr_lsb_i))); // R3

  AST_HEIGHT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    height_i != 11'd0); // R6

  AST_HRES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hres_i inside {10'd256, 10'd320, 10'd368, 10'd384, 10'd512, 10'd640}); // R7

  AST_BUSY_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !wr_ready_i); // R9

  AST_WIDTH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(width_i)); // R9
endmodule

bind disp_ctrl_decoder disp_ctrl_decoder_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_cmd_i    (wr_data_i[31:24]),
  .wr_lsb_i    (wr_data_i[0]),
  .wr_ready_i  (wr_ready_o),
  .status_i    (status_o),
  .hres_i      (hres_o),
  .width_i     (width_o),
  .height_i    (height_o),
  .busy_i      (busy_o),
  .full_reset_i(full_reset_o),
  .cmd_reset_i (cmd_reset_o)
);

// File: tb/disp_ctrl_decoder_tb_top.sv
module disp_ctrl_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [79:0] env_info;
  logic        wr_ready, busy, full_rst, cmd_rst;
  logic [31:0] status, readback;
  logic [9:0]  hres, width, disp_x;
  logic [8:0]  vres, disp_y;
  logic [10:0] height;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // reference model state
  logic [31:0] m_status;
  logic [31:0] m_shadow [16];
  int          m_x1, m_x2, m_y1, m_y2, m_w, m_h, m_sx, m_sy;
  logic [31:0] m_rb;
  int          m_env [8];
  bit          m_full, m_qrst;
  bit          saw_busy;

  always #5 clk = ~clk;

  disp_ctrl_decoder dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_valid_i  (wr_valid),
    .wr_data_i   (wr_data),
    .wr_ready_o  (wr_ready),
    .env_info_i  (env_info),
    .status_o    (status),
    .hres_o      (hres),
    .vres_o      (vres),
    .width_o     (width),
    .height_o    (height),
    .disp_x_o    (disp_x),
    .disp_y_o    (disp_y),
    .busy_o      (busy),
    .full_reset_o(full_rst),
    .cmd_reset_o (cmd_rst),
    .readback_o  (readback)
  );

  function automatic int m_hres();
    int t [8] = '{256, 368, 320, 384, 512, 512, 640, 640};
    return t[m_status[18:16]];
  endfunction

  function automatic int m_vres();
    int t [4] = '{240, 480, 256, 480};
    return t[m_status[20:19]];
  endfunction

  function automatic void m_calc_w();
    int sw = m_x2 - m_x1;
    if (sw <= 0 || sw >= 2560) m_w = m_hres();
    else m_w = (sw * m_hres()) / 2560;
  endfunction

  function automatic void m_calc_h();
    int sh = m_y2 - m_y1;
    if (m_status[19]) sh = sh * 2;
    m_h = (sh <= 0) ? m_vres() : sh;
  endfunction

  function automatic void m_init();
    m_status = 32'h1480_2000;
    for (int i = 0; i < 16; i++) m_shadow[i] = (i == 3) ? 32'd1 : 32'd0;
    m_w = 256;
    m_h = 240;
    m_rb = 0;
  endfunction

  function automatic void m_apply(input logic [31:0] d);
    int c = int'(d[31:24]);
    int key = int'(d[3:0]);
    m_full = (c == 0);
    m_qrst = (c <= 1);
    if (c < 16 && c > 1 && c != 5 && m_shadow[c] == d) return;
    if (c < 16) m_shadow[c] = d;
    case (c)
      0: m_init();
      3: m_status[23] = d[0];
      4: m_status[30:29] = d[1:0];
      5: begin m_sx = int'(d[9:0]); m_sy = int'(d[18:10]); end
      6: begin m_x1 = int'(d[11:0]); m_x2 = int'(d[23:12]); m_calc_w(); end
      7: begin m_y1 = int'(d[9:0]); m_y2 = int'(d[19:10]); m_calc_h(); end
      8: begin
        m_status[22:17] = d[5:0];
        m_status[16] = d[6];
        m_calc_w();
        m_calc_h();
      end
      default:
        if (c >= 16 && c < 32) begin
          if (key >= 2 && key <= 5) m_rb = m_env[key];
          else if (key == 6) m_rb = m_env[5];
          else if (key == 7) m_rb = 2;
          else m_rb = 0;
        end
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "status", status, m_status);
    chk(tag, "hres", hres, m_hres());
    chk(tag, "vres", vres, m_vres());
    chk(tag, "width", width, m_w);
    chk(tag, "height", height, m_h);
    chk(tag, "disp_x", disp_x, m_sx);
    chk(tag, "disp_y", disp_y, m_sy);
    chk(tag, "readback", readback, m_rb);
  endtask

  task automatic settle();
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    m_apply(d);
    chk("R2", "full_reset pulse", full_rst, m_full);
    chk("R2", "cmd_reset pulse", cmd_rst, m_qrst);
    settle();
    compare_all(tag);
  endtask

  always @(negedge clk) if (busy) saw_busy = 1'b1;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_env[k] = 0;
    m_env[2] = 20'hA1111;
    m_env[3] = 20'hB2222;
    m_env[4] = 20'hC3333;
    m_env[5] = 20'hD4444;
    env_info = {20'hD4444, 20'hC3333, 20'hB2222, 20'hA1111};
    m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; m_sx = 0; m_sy = 0;
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_all("R1");
    chk("R1", "ready after reset", wr_ready, 1);

    // R7 modes and resolution lookup
    wr(32'h0800_0001, "R7");
    wr(32'h0800_0040, "R7");
    wr(32'h0800_0007, "R7");
    // R5 window scaling with hres 640
    wr({8'h06, 12'd2608, 12'd608}, "R5");
    wr({8'h06, 12'd3168, 12'd608}, "R5");
    wr({8'h06, 12'd3167, 12'd608}, "R5");
    wr({8'h06, 12'd500, 12'd1000}, "R5");
    wr({8'h06, 12'd1000, 12'd999}, "R5");
    wr({8'h06, 12'd1700, 12'd500}, "R5");
    // R6 height, doubled (status bit 19 set by mode 7)
    wr({8'h07, 4'd0, 10'd256, 10'd16}, "R6");
    wr(32'h0800_0000, "R7");
    wr({8'h07, 4'd0, 10'd100, 10'd300}, "R6");
    wr({8'h07, 4'd0, 10'd50, 10'd50}, "R6");
    wr(32'h0800_0022, "R7");
    // R3 blanking and direction
    wr(32'h0300_0000, "R3");
    wr(32'h0300_0001, "R3");
    wr(32'h0400_0002, "R3");
    wr(32'h0400_0001, "R3");
    // R4 display start
    wr({8'h05, 5'd0, 9'd300, 10'd777}, "R4");
    wr({8'h05, 5'd0, 9'd511, 10'd1023}, "R4");

    // R10 repeated window write starts no division
    wr({8'h06, 12'd2000, 12'd100}, "R10");
    saw_busy = 1'b0;
    wr({8'h06, 12'd2000, 12'd100}, "R10");
    chk("R10", "busy on repeated word", saw_busy, 0);
    wr(32'h0300_0000, "R10");
    wr(32'h0300_0000, "R10");

    // R8 queries
    for (int k = 0; k < 16; k++) wr(32'h1000_0000 | k, "R8");
    wr(32'h1F00_0013, "R8");

    // R9 write held off by running division
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = {8'h06, 12'd2900, 12'd700};
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    m_apply(wr_data);
    wr_data = 32'h1000_0007;
    chk("R9", "ready after window write", wr_ready, 0);
    @(negedge clk);
    chk("R9", "busy while dividing", busy, 1);
    chk("R9", "readback held", readback, m_rb);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    m_apply(32'h1000_0007);
    settle();
    compare_all("R9");

    // R1 R2 full reset and queue reset
    wr(32'h0100_0000, "R2");
    wr(32'h0100_0000, "R2");
    wr(32'h0000_0000, "R1");
    wr(32'h0300_0001, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule